// File: doc/BRIEF.md
# Serial Control-Register Port

This block is the slave end of a four-wire control link from a microcontroller. The link has a shift clock, a serial data input, a tri-state serial data output and two active-low strobes: one marks a write frame and the other a read frame. Every frame is eight shift-clock periods long. The first three bits carry a register address, most significant bit first. The last five bits carry register data, also most significant bit first. The block holds eight five-bit control registers and presents their contents to the rest of the chip. It also exposes the general latch output, the sixth path switch and the five power enables as named pins.

All link inputs are taken as already synchronous to the system clock `clk`. A shift-clock rising edge is seen one `clk` cycle after it appears at the `dclk` pin. A frame controller tracks the link in five named states. IDLE waits with both strobes high. It goes to WRITE when only the write strobe is low, to RADDR when only the read strobe is low, and to BLOCK when both are low. WRITE shifts bits in and returns to IDLE when its strobe rises. It commits the frame at that point only if exactly eight edges were taken. WRITE goes to BLOCK if the read strobe falls. RADDR shifts in the three address bits. On the fourth edge it loads the readback word and moves to RDATA. RDATA drives the data output and returns to IDLE when its strobe rises. Both RADDR and RDATA fall into BLOCK if the write strobe drops. BLOCK discards the frame and returns to IDLE only when both strobes are high.

Top module: `ctlreg_serial_port`

## Requirements
- R1: A write frame (`wr_n` low, `rd_n` high) with exactly eight `dclk` rising edges stores its last five bits into the register whose index is its first three bits. The store takes effect in the `clk` cycle after `wr_n` is seen high again.
- R2: A write frame that ends after fewer than eight `dclk` rising edges changes no register.
- R3: Edges after the eighth in a write frame are ignored, and the frame commits the bits from its first eight edges.
- R4: In a read frame the address is taken on edges 1 to 3. The register's bits 4 down to 0 then appear on `cdout` one `clk` cycle after edges 4, 5, 6, 7 and 8 respectively, and bit 0 is held until the strobe rises.
- R5: `cdout_oe` rises only after the fourth edge of a read frame. It is low in the cycle after `rd_n` is seen high. `cdout` reads 0 whenever `cdout_oe` is low.
- R6: Registers 0, 1, 2, 3 and 7 read back their contents. Registers 4, 5 and 6 are writable but read back as 00000, with `cdout_oe` still high during the data phase.
- R7: While both strobes are low, and until both are high again, the frame is dropped. No register changes and `cdout_oe` is low from the next cycle.
- R8: While `rst_n` is low, all eight registers are 00000 and `cdout_oe` is low. This gives 0 dB gains, all switches off, latch 0, tones stopped and all power domains off.
- R9: Register 3 keeps only its two low bits; bits 4 to 2 always read 0. Bit 0 drives `latch_out` and bit 1 drives `sw6_en`.
- R10: `pwr_en[4:0]` equals register 7. Bit 4 powers the codec, bit 3 the speaker, bit 2 the earpiece, bit 1 the tone generator and bit 0 the reference and PLL.
- R11: Register contents change only through a committed write. A read frame, a dropped frame or shift activity alone leaves `regs_flat` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of registers and controller |
| dclk | input | 1 | Serial shift clock, sampled on `clk` |
| wr_n | input | 1 | Active-low write frame strobe |
| rd_n | input | 1 | Active-low read frame strobe |
| cdin | input | 1 | Serial address and data input |
| cdout | output | 1 | Serial readback data, 0 when not enabled |
| cdout_oe | output | 1 | Output enable for the `cdout` pad driver |
| regs_flat | output | 40 | All registers, register n in bits 5n+4 to 5n |
| latch_out | output | 1 | General latch output, register 3 bit 0 |
| sw6_en | output | 1 | Path switch 6 enable, register 3 bit 1 |
| pwr_en | output | 5 | Power enables, a copy of register 7 |

## Verification
A miscounted edge counter shows up in two ways. On a write it either drops a full frame or commits a short one, and `regs_flat` differs from the model one cycle after the strobe rises. On a read it shifts the readback word, so `cdout` is wrong one cycle after the fourth edge. A state that fails to leave BLOCK or RDATA shows up as `cdout_oe` held high, or as a later write that never lands, in the cycle after the strobes return. The reference model checks every output on every clock, so any wrong value is reported within one cycle of appearing.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    // Frame controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RADDR,
        ST_RDATA,
        ST_BLOCK
    } port_state_e;

endpackage

// File: rtl/ctlreg_edge.sv
module ctlreg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk,
    output logic rise
);

    logic dclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dclk_q <= 1'b0;
        end else begin
            dclk_q <= dclk;
        end
    end

    assign rise = dclk & ~dclk_q;

endmodule

// File: rtl/ctlreg_fsm.sv
module ctlreg_fsm
    import ctlreg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cdin,
    input  logic              rise,
    input  logic [DATA_W-1:0] rd_value,
    output logic              commit,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cdout,
    output logic              cdout_oe
);

    localparam int FRAME = ADDR_W + DATA_W;
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);

    port_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAME-1:0]  in_q;
    logic [DATA_W-1:0] out_q;
    logic              wr_only, rd_only, both_hi, both_lo;

    assign wr_only = !wr_n &&  rd_n;
    assign rd_only =  wr_n && !rd_n;
    assign both_hi =  wr_n &&  rd_n;
    assign both_lo = !wr_n && !rd_n;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (both_lo)      state_d = ST_BLOCK;
                else if (wr_only) state_d = ST_WRITE;
                else if (rd_only) state_d = ST_RADDR;
            end
            ST_WRITE: begin
                if (!rd_n)        state_d = ST_BLOCK;
                else if (wr_n)    state_d = ST_IDLE;
            end
            ST_RADDR: begin
                if (!wr_n)        state_d = ST_BLOCK;
                else if (rd_n)    state_d = ST_IDLE;
                else if (rise && cnt_q == CNT_ADDR) state_d = ST_RDATA;
            end
            ST_RDATA: begin
                if (!wr_n)        state_d = ST_BLOCK;
                else if (rd_n)    state_d = ST_IDLE;
            end
            ST_BLOCK: begin
                if (both_hi)      state_d = ST_IDLE;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift datapath and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            in_q  <= '0;
            out_q <= '0;
        end else begin
            unique case (state_q)
                ST_WRITE: begin
                    if (wr_only && rise && cnt_q != CNT_FULL) begin
                        in_q  <= {in_q[FRAME-2:0], cdin};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RADDR: begin
                    if (rd_only && rise) begin
                        if (cnt_q == CNT_ADDR) begin
                            out_q <= rd_value;
                        end else begin
                            in_q <= {in_q[FRAME-2:0], cdin};
                        end
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (rd_only && rise && cnt_q != CNT_FULL) begin
                        out_q <= {out_q[DATA_W-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        commit     = (state_q == ST_WRITE) && both_hi && (cnt_q == CNT_FULL);
        frame_addr = in_q[FRAME-1 -: ADDR_W];
        frame_data = in_q[DATA_W-1:0];
        rd_addr    = in_q[ADDR_W-1:0];
        cdout_oe   = (state_q == ST_RDATA);
        cdout      = cdout_oe & out_q[DATA_W-1];
    end

endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 5,
    parameter logic [(2**ADDR_W)-1:0] READ_MASK = 8'b1000_1111,
    parameter int LATCH_REG = 3,
    parameter logic [DATA_W-1:0] LATCH_KEEP = 5'b00011
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               waddr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [ADDR_W-1:0]               raddr,
    output logic [DATA_W-1:0]               rd_value,
    output logic [(2**ADDR_W)*DATA_W-1:0]   regs_flat
);

    localparam int NREG = 2 ** ADDR_W;

    logic [NREG-1:0][DATA_W-1:0] regs_w;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] KEEP = (g == LATCH_REG) ? LATCH_KEEP : '1;
        logic [DATA_W-1:0] r_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (we && waddr == ADDR_W'(g)) begin
                r_q <= wdata & KEEP;
            end
        end

        assign regs_w[g] = r_q;
    end

    assign regs_flat = regs_w;
    assign rd_value  = READ_MASK[raddr] ? regs_w[raddr] : '0;

endmodule

// File: rtl/ctlreg_serial_port.sv
module ctlreg_serial_port #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            dclk,
    input  logic                            wr_n,
    input  logic                            rd_n,
    input  logic                            cdin,
    output logic                            cdout,
    output logic                            cdout_oe,
    output logic [(2**ADDR_W)*DATA_W-1:0]   regs_flat,
    output logic                            latch_out,
    output logic                            sw6_en,
    output logic [DATA_W-1:0]               pwr_en
);

    localparam int NREG      = 2 ** ADDR_W;
    localparam int LATCH_REG = 3;
    localparam int POWER_REG = NREG - 1;

    logic              rise;
    logic              commit;
    logic [ADDR_W-1:0] frame_addr;
    logic [DATA_W-1:0] frame_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_value;

    ctlreg_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .dclk  (dclk),
        .rise  (rise)
    );

    ctlreg_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .cdin       (cdin),
        .rise       (rise),
        .rd_value   (rd_value),
        .commit     (commit),
        .frame_addr (frame_addr),
        .frame_data (frame_data),
        .rd_addr    (rd_addr),
        .cdout      (cdout),
        .cdout_oe   (cdout_oe)
    );

    ctlreg_file #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .READ_MASK  (NREG'(8'b1000_1111)),
        .LATCH_REG  (LATCH_REG),
        .LATCH_KEEP (DATA_W'(3))
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (commit),
        .waddr     (frame_addr),
        .wdata     (frame_data),
        .raddr     (rd_addr),
        .rd_value  (rd_value),
        .regs_flat (regs_flat)
    );

    assign latch_out = regs_flat[LATCH_REG*DATA_W];
    assign sw6_en    = regs_flat[LATCH_REG*DATA_W + 1];
    assign pwr_en    = regs_flat[POWER_REG*DATA_W +: DATA_W];

endmodule

// File: rtl/ctlreg_serial_port_chk.sv
module ctlreg_serial_port_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            dclk,
    input logic                            wr_n,
    input logic                            rd_n,
    input logic                            cdout_oe,
    input logic [(2**ADDR_W)*DATA_W-1:0]   regs_flat
);

    localparam int LATCH_REG = 3;

    // R11
    regs_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> ($past(wr_n) && $past(rd_n)));

    // R5
    oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> !cdout_oe);

    // R5
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cdout_oe) |-> $past(!rd_n && wr_n && dclk));

    // R7
    conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !rd_n) |=> !cdout_oe);

    // R9
    latch_reg_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_flat[LATCH_REG*DATA_W + 2 +: DATA_W - 2] == '0);

    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (regs_flat == '0 && !cdout_oe));

endmodule

bind ctlreg_serial_port ctlreg_serial_port_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dclk      (dclk),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .cdout_oe  (cdout_oe),
    .regs_flat (regs_flat)
);

// File: tb/ctlreg_serial_port_tb.sv
`timescale 1ns/1ps
module ctlreg_serial_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dclk = 1'b0;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        cdin = 1'b0;
    logic        cdout, cdout_oe, latch_out, sw6_en;
    logic [39:0] regs_flat;
    logic [4:0]  pwr_en;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string cur_req  = "R8";

    always #2.5 clk = ~clk;

    ctlreg_serial_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dclk      (dclk),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .cdin      (cdin),
        .cdout     (cdout),
        .cdout_oe  (cdout_oe),
        .regs_flat (regs_flat),
        .latch_out (latch_out),
        .sw6_en    (sw6_en),
        .pwr_en    (pwr_en)
    );

    // Behavioural reference model
    logic [4:0] m_reg [8];
    int         m_mode = 0;   // 0 idle, 1 write, 2 read, 3 dropped
    int         m_edges = 0;
    bit         m_bits [$];
    logic       m_prev = 1'b0;
    logic       m_oe = 1'b0;
    logic       m_do = 1'b0;
    logic [4:0] m_val = '0;

    function automatic logic [39:0] m_pack();
        logic [39:0] p;
        for (int i = 0; i < 8; i++) p[i*5 +: 5] = m_reg[i];
        return p;
    endfunction

    always @(posedge clk) begin
        bit rs;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_reg[i] = '0;
            m_mode = 0; m_edges = 0; m_bits.delete();
            m_prev = 1'b0; m_oe = 1'b0; m_do = 1'b0;
        end else begin
            rs = dclk && !m_prev;
            m_prev = dclk;
            case (m_mode)
                0: begin
                    m_edges = 0; m_bits.delete();
                    if (!wr_n && !rd_n) m_mode = 3;
                    else if (!wr_n)     m_mode = 1;
                    else if (!rd_n)     m_mode = 2;
                end
                1: begin
                    if (!rd_n) m_mode = 3;
                    else if (wr_n) begin
                        if (m_edges == 8) begin
                            int a; logic [4:0] d;
                            a = {m_bits[0], m_bits[1], m_bits[2]};
                            d = {m_bits[3], m_bits[4], m_bits[5], m_bits[6], m_bits[7]};
                            if (a == 3) d = d & 5'b00011;
                            m_reg[a] = d;
                        end
                        m_mode = 0;
                    end else if (rs && m_edges < 8) begin
                        m_bits.push_back(cdin);
                        m_edges++;
                    end
                end
                2: begin
                    if (!wr_n) begin m_mode = 3; m_oe = 0; m_do = 0; end
                    else if (rd_n) begin m_mode = 0; m_oe = 0; m_do = 0; end
                    else if (rs && m_edges < 8) begin
                        m_edges++;
                        if (m_edges <= 3) m_bits.push_back(cdin);
                        if (m_edges == 4) begin
                            int a;
                            a = {m_bits[0], m_bits[1], m_bits[2]};
                            m_val = (a >= 4 && a <= 6) ? 5'd0 : m_reg[a];
                            m_oe = 1; m_do = m_val[4];
                        end else if (m_edges > 4) begin
                            m_do = m_val[8 - m_edges];
                        end
                    end
                end
                default: begin
                    if (wr_n && rd_n) m_mode = 0;
                end
            endcase
        end
    end

    task automatic check(string req, logic [39:0] got, logic [39:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(cur_req, regs_flat, m_pack());
            check(cur_req, {39'd0, cdout_oe}, {39'd0, m_oe});
            check(cur_req, {39'd0, cdout}, {39'd0, m_oe & m_do});
            check("R9", {38'd0, sw6_en, latch_out}, {38'd0, m_reg[3][1:0]});
            check("R10", {35'd0, pwr_en}, {35'd0, m_reg[7]});
        end
    end

    task automatic pulse(input logic b, output logic s_oe, output logic s_do);
        cdin = b;
        @(negedge clk); dclk = 1'b1;
        @(negedge clk); s_oe = cdout_oe; s_do = cdout;
        @(negedge clk); dclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_frame(input int addr, input logic [4:0] data, input int nedge);
        logic [7:0] f;
        logic so, sd;
        f = {addr[2:0], data};
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < nedge; i++) pulse((i < 8) ? f[7-i] : 1'b1, so, sd);
        wr_n = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
    endtask

    task automatic read_frame(input int addr, output logic [4:0] got);
        logic [2:0] a;
        logic so, sd;
        a = addr[2:0];
        got = '0;
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            pulse((i < 3) ? a[2-i] : 1'b0, so, sd);
            if (i == 2) check("R5", {39'd0, so}, 40'd0);
            if (i >= 3) begin
                check("R5", {39'd0, so}, 40'd1);
                got[7-i] = sd;
            end
        end
        rd_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R5", {39'd0, cdout_oe}, 40'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [4:0]  rv;
        logic [39:0] snap;
        repeat (4) @(negedge clk);
        check("R8", regs_flat, 40'd0);
        check("R8", {39'd0, cdout_oe}, 40'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        cur_req = "R1";
        write_frame(2, 5'b10110, 8);
        check("R1", {35'd0, regs_flat[14:10]}, {35'd0, 5'b10110});
        write_frame(0, 5'b01101, 8);
        check("R1", {35'd0, regs_flat[4:0]}, {35'd0, 5'b01101});

        cur_req = "R4";
        read_frame(0, rv);
        check("R4", {35'd0, rv}, {35'd0, 5'b01101});
        read_frame(2, rv);
        check("R4", {35'd0, rv}, {35'd0, 5'b10110});

        cur_req = "R2";
        write_frame(1, 5'b11011, 8);
        write_frame(1, 5'b00100, 5);
        check("R2", {35'd0, regs_flat[9:5]}, {35'd0, 5'b11011});

        cur_req = "R3";
        write_frame(1, 5'b01010, 11);
        check("R3", {35'd0, regs_flat[9:5]}, {35'd0, 5'b01010});

        cur_req = "R6";
        write_frame(4, 5'b10011, 8);
        write_frame(5, 5'b11111, 8);
        write_frame(6, 5'b10001, 8);
        check("R6", {35'd0, regs_flat[24:20]}, {35'd0, 5'b10011});
        read_frame(4, rv);
        check("R6", {35'd0, rv}, 40'd0);
        read_frame(5, rv);
        check("R6", {35'd0, rv}, 40'd0);
        read_frame(6, rv);
        check("R6", {35'd0, rv}, 40'd0);

        cur_req = "R9";
        write_frame(3, 5'b11111, 8);
        check("R9", {35'd0, regs_flat[19:15]}, {35'd0, 5'b00011});
        check("R9", {38'd0, sw6_en, latch_out}, 40'd3);
        write_frame(3, 5'b11101, 8);
        check("R9", {38'd0, sw6_en, latch_out}, 40'd1);
        read_frame(3, rv);
        check("R9", {35'd0, rv}, {35'd0, 5'b00001});

        cur_req = "R10";
        write_frame(7, 5'b10101, 8);
        check("R10", {35'd0, pwr_en}, {35'd0, 5'b10101});
        read_frame(7, rv);
        check("R10", {35'd0, rv}, {35'd0, 5'b10101});

        cur_req = "R7";
        snap = regs_flat;
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            logic so, sd;
            pulse(1'b1, so, sd);
        end
        rd_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            logic so, sd;
            pulse(1'b1, so, sd);
            check("R7", {39'd0, so}, 40'd0);
        end
        rd_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", regs_flat, snap);

        cur_req = "R11";
        snap = regs_flat;
        read_frame(1, rv);
        check("R11", regs_flat, snap);
        check("R4", {35'd0, rv}, {35'd0, 5'b01010});

        cur_req = "R8";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R8", regs_flat, 40'd0);
        check("R8", {37'd0, sw6_en, latch_out, cdout_oe}, 40'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        write_frame(5, 5'b00110, 8);
        check("R1", {35'd0, regs_flat[29:25]}, {35'd0, 5'b00110});

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule